// File: doc/BRIEF.md
# Splittable Up/Down Interval Timer

This block holds two 16-bit counting channels, A and B. They either chain into a single 32-bit counter under channel A's settings, or run apart as two 16-bit counters. When they run apart, each channel has an 8-bit prescale stage below its main count. Each channel can count up or down. It can stop after one interval (one-shot) or restart on its own (periodic). It can also be told to stay parked after enable until a pulse arrives on its trigger pin.

Software drives the block through a flat word-addressed register port. Writes are strobed by `wr_en` and reads are combinational from `addr`. Every timeout sets a sticky status bit for its channel. The interrupt line is high while any status bit is set whose mask bit is also set.

Register indices (decoded by `addr`): 0 configuration (bits 2:0), 1 enables (bit 0 = A, bit 1 = B), 2 and 3 mode for A and B, 4 and 5 interval load for A and B, 6 and 7 prescale for A and B, 8 and 9 live value for A and B, 10 raw status (bit 0 = A, bit 1 = B), 11 interrupt mask, 12 status clear (write-only, reads zero). In a mode word, bit 0 = 1 selects periodic (0 selects one-shot), bit 1 = 1 selects up-count (0 selects down-count), and bit 2 = 1 selects wait-for-trigger.

Top module: `split_interval_timer`

## Requirements
- R1: After reset, both counts read all ones, both interval loads read all ones, both prescale values and the live prescale stages are zero, and configuration, enables, modes, status and mask are zero.
- R2: A configuration value of 4 selects split operation. Any other value chains the channels into one 32-bit counter run by A's enable and mode. In that chained mode, the enable write for B is ignored (bit 1 of the enable register reads 0) and B never reports a timeout. A write to index 4 loads bits 15:0 into A's load and bits 31:16 into B's load.
- R3: Enabling a down-counting channel loads its interval value into the count and its prescale value into the prescale stage. Counting then proceeds toward zero, and the timeout is the cycle in which both read zero.
- R4: Enabling an up-counting channel clears its count and prescale stage. The timeout is the cycle in which the count equals the interval load and the prescale stage equals the prescale value.
- R5: In periodic mode, on the clock after a timeout, a down-counting channel reloads its interval and prescale values and an up-counting channel returns to zero.
- R6: In one-shot mode, on the clock after a timeout, the channel clears its own enable bit and keeps its count.
- R7: With wait-for-trigger set, enabling a channel loads its start value but holds it. Counting begins only after a high cycle on that channel's trigger input. A trigger while the channel is idle or running has no effect.
- R8: In split operation, the prescale stage steps every clock and the main count steps once each time the stage wraps. In chained operation, the prescale value is ignored and the 32-bit count steps every clock.
- R9: Each timeout sets that channel's raw status bit, which stays set until a 1 is written to the matching bit of the clear register. `irq` equals the OR of raw status ANDed with the mask.
- R10: In split operation, a value read returns the 16-bit count in bits 15:0 and the prescale stage in bits 23:16. In chained operation, A's value read returns the 32-bit count, and B's value read returns its upper half in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| trig_a | input | 1 | Start pulse for channel A when waiting |
| trig_b | input | 1 | Start pulse for channel B when waiting |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest condition to reach from the ports is a chained count that borrows across the 16-bit boundary while a stale prescale value sits in A's register. That case proves both the carry chain and the prescale bypass at once. The bench loads a start value just above the boundary with a non-zero prescale value in chained mode, then reads the value a couple of cycles later. A long random phase follows, with small loads, mode flips, configuration flips and trigger pulses. It drives timeouts, status set/clear collisions and forced stops of B, and a behavioural model is compared against the outputs on every clock.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      RG_CFG    = 4'd0,
      RG_CTRL   = 4'd1,
      RG_MODE_A = 4'd2,
      RG_MODE_B = 4'd3,
      RG_LOAD_A = 4'd4,
      RG_LOAD_B = 4'd5,
      RG_PRE_A  = 4'd6,
      RG_PRE_B  = 4'd7,
      RG_VAL_A  = 4'd8,
      RG_VAL_B  = 4'd9,
      RG_RAW    = 4'd10,
      RG_MASK   = 4'd11,
      RG_CLR    = 4'd12
   } reg_idx_e;

   localparam logic [2:0] CFG_SPLIT = 3'd4;

   // mode word: bit2 wait-for-trigger, bit1 up-count, bit0 periodic
   typedef struct packed {
      logic wot;
      logic up;
      logic periodic;
   } chan_mode_t;

   typedef enum logic [1:0] {CH_IDLE, CH_WAIT, CH_RUN} chan_st_e;
endpackage

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CW    = 32,
   parameter int PW    = 8,
   parameter bit PS_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic          trig_i,
   input  chan_mode_t    mode_i,
   input  logic [CW-1:0] load_i,
   input  logic [PW-1:0] pre_i,
   output logic [CW-1:0] cnt_o,
   output logic [PW-1:0] ps_o,
   output logic          timeout_o,
   output logic          waiting_o,
   output logic          done_o
);
   chan_st_e      st;
   logic [CW-1:0] cnt, cnt_step;
   logic [PW-1:0] ps, ps_step, pre_eff;
   logic          reached;

   generate
      if (PS_EN) begin : g_ps
         assign pre_eff = pre_i;
      end else begin : g_nops
         logic unused_pre;
         assign unused_pre = ^pre_i;
         assign pre_eff    = '0;
      end
   endgenerate

   assign reached   = mode_i.up ? (cnt == load_i && ps == pre_eff)
                                : (cnt == '0 && ps == '0);
   assign timeout_o = (st == CH_RUN) && reached;
   assign done_o    = timeout_o && !mode_i.periodic;
   assign waiting_o = (st == CH_WAIT);
   assign cnt_o     = cnt;
   assign ps_o      = ps;

   always_comb begin
      cnt_step = cnt;
      ps_step  = ps;
      if (mode_i.up) begin
         if (ps == pre_eff) begin
            ps_step  = '0;
            cnt_step = cnt + 1'b1;
         end else begin
            ps_step = ps + 1'b1;
         end
      end else begin
         if (ps == '0) begin
            ps_step  = pre_eff;
            cnt_step = cnt - 1'b1;
         end else begin
            ps_step = ps - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= CH_IDLE;
         cnt <= '1;
         ps  <= '0;
      end else if (start_i) begin
         cnt <= mode_i.up ? '0 : load_i;
         ps  <= mode_i.up ? '0 : pre_eff;
         st  <= mode_i.wot ? CH_WAIT : CH_RUN;
      end else if (stop_i) begin
         st <= CH_IDLE;
      end else begin
         case (st)
            CH_WAIT: if (trig_i) st <= CH_RUN;
            CH_RUN: begin
               if (reached) begin
                  if (mode_i.periodic) begin
                     cnt <= mode_i.up ? '0 : load_i;
                     ps  <= mode_i.up ? '0 : pre_eff;
                  end else begin
                     st <= CH_IDLE;
                  end
               end else begin
                  cnt <= cnt_step;
                  ps  <= ps_step;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int PS_W   = 8,
   localparam int FULL_W = 2*HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [FULL_W-1:0] wdata,
   output logic [FULL_W-1:0] rdata,
   input  logic [FULL_W-1:0] cnt_a,
   input  logic [PS_W-1:0]   ps_a,
   input  logic [HALF_W-1:0] cnt_b,
   input  logic [PS_W-1:0]   ps_b,
   input  logic              tmo_a,
   input  logic              tmo_b,
   input  logic              done_a,
   input  logic              done_b,
   output logic              split,
   output chan_mode_t        mode_a,
   output chan_mode_t        mode_b,
   output logic [FULL_W-1:0] load_a_eff,
   output logic [HALF_W-1:0] load_b,
   output logic [PS_W-1:0]   pre_a_eff,
   output logic [PS_W-1:0]   pre_b,
   output logic              start_a,
   output logic              stop_a,
   output logic              start_b,
   output logic              stop_b,
   output logic              en_a,
   output logic [1:0]        raw,
   output logic              irq
);
   logic [2:0]        cfg;
   logic [HALF_W-1:0] ld_a;
   logic [PS_W-1:0]   pr_a;
   logic              en_b;
   logic [1:0]        mask;
   logic              wr_ctrl;
   logic [1:0]        clr_bits;

   assign split      = (cfg == CFG_SPLIT);
   assign wr_ctrl    = wr_en && (addr == RG_CTRL);
   assign clr_bits   = (wr_en && addr == RG_CLR) ? wdata[1:0] : 2'b00;
   assign start_a    = wr_ctrl && wdata[0] && !en_a;
   assign stop_a     = wr_ctrl && !wdata[0] && en_a;
   assign start_b    = split && wr_ctrl && wdata[1] && !en_b;
   assign stop_b     = (wr_ctrl && !wdata[1] && en_b) || !split;
   assign load_a_eff = split ? {{HALF_W{1'b0}}, ld_a} : {load_b, ld_a};
   assign pre_a_eff  = split ? pr_a : '0;
   assign irq        = |(raw & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         mode_a <= '0;
         mode_b <= '0;
         ld_a   <= '1;
         load_b <= '1;
         pr_a   <= '0;
         pre_b  <= '0;
         en_a   <= 1'b0;
         en_b   <= 1'b0;
         raw    <= '0;
         mask   <= '0;
      end else begin
         if (wr_en) begin
            case (reg_idx_e'(addr))
               RG_CFG:    cfg    <= wdata[2:0];
               RG_MODE_A: mode_a <= chan_mode_t'(wdata[2:0]);
               RG_MODE_B: mode_b <= chan_mode_t'(wdata[2:0]);
               RG_LOAD_A: begin
                  ld_a <= wdata[HALF_W-1:0];
                  if (!split) load_b <= wdata[FULL_W-1:HALF_W];
               end
               RG_LOAD_B: load_b <= wdata[HALF_W-1:0];
               RG_PRE_A:  pr_a   <= wdata[PS_W-1:0];
               RG_PRE_B:  pre_b  <= wdata[PS_W-1:0];
               RG_MASK:   mask   <= wdata[1:0];
               default: ;
            endcase
         end
         if (done_a)       en_a <= 1'b0;
         else if (wr_ctrl) en_a <= wdata[0];
         if (!split || done_b) en_b <= 1'b0;
         else if (wr_ctrl)     en_b <= wdata[1];
         raw <= (raw & ~clr_bits) | {tmo_b, tmo_a};
      end
   end

   always_comb begin
      rdata = '0;
      case (reg_idx_e'(addr))
         RG_CFG:    rdata[2:0] = cfg;
         RG_CTRL:   rdata[1:0] = {en_b, en_a};
         RG_MODE_A: rdata[2:0] = mode_a;
         RG_MODE_B: rdata[2:0] = mode_b;
         RG_LOAD_A: rdata      = load_a_eff;
         RG_LOAD_B: rdata[HALF_W-1:0] = load_b;
         RG_PRE_A:  rdata[PS_W-1:0]   = pr_a;
         RG_PRE_B:  rdata[PS_W-1:0]   = pre_b;
         RG_VAL_A: begin
            if (split) begin
               rdata[HALF_W-1:0]           = cnt_a[HALF_W-1:0];
               rdata[HALF_W+PS_W-1:HALF_W] = ps_a;
            end else begin
               rdata = cnt_a;
            end
         end
         RG_VAL_B: begin
            if (split) begin
               rdata[HALF_W-1:0]           = cnt_b;
               rdata[HALF_W+PS_W-1:HALF_W] = ps_b;
            end else begin
               rdata[HALF_W-1:0] = cnt_a[FULL_W-1:HALF_W];
            end
         end
         RG_RAW:  rdata[1:0] = raw;
         RG_MASK: rdata[1:0] = mask;
         default: ;
      endcase
   end
endmodule

// File: rtl/split_interval_timer.sv
`timescale 1ns/1ps
module split_interval_timer
   import tmr_pkg::*;
#(
   parameter int HALF_W       = 16,
   parameter int PS_W         = 8,
   parameter bit PRESCALE_EN  = 1'b1,
   localparam int FULL_W      = 2*HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [FULL_W-1:0] wdata,
   output logic [FULL_W-1:0] rdata,
   input  logic              trig_a,
   input  logic              trig_b,
   output logic              irq
);
   generate
      if (HALF_W <= PS_W) begin : g_bad_widths
         $error("HALF_W must exceed PS_W so the value read can hold both fields");
      end
      if (FULL_W != 32) begin : g_bad_bus
         $error("register data path is sized for a 32-bit chained count");
      end
   endgenerate

   logic              split_w, en_a_w;
   chan_mode_t        mode_a_w, mode_b_w;
   logic [FULL_W-1:0] load_a_eff_w, cnt_a_w;
   logic [HALF_W-1:0] load_b_w, cnt_b_w;
   logic [PS_W-1:0]   pre_a_w, pre_b_w, ps_a_w, ps_b_w;
   logic              start_a_w, stop_a_w, start_b_w, stop_b_w;
   logic              tmo_a_w, tmo_b_w, done_a_w, done_b_w;
   logic              wait_a_w, wait_b_w;
   logic [1:0]        raw_w;

   tmr_regs #(.HALF_W(HALF_W), .PS_W(PS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cnt_a(cnt_a_w), .ps_a(ps_a_w), .cnt_b(cnt_b_w),
      .ps_b(ps_b_w), .tmo_a(tmo_a_w), .tmo_b(tmo_b_w), .done_a(done_a_w),
      .done_b(done_b_w), .split(split_w), .mode_a(mode_a_w), .mode_b(mode_b_w),
      .load_a_eff(load_a_eff_w), .load_b(load_b_w), .pre_a_eff(pre_a_w),
      .pre_b(pre_b_w), .start_a(start_a_w), .stop_a(stop_a_w),
      .start_b(start_b_w), .stop_b(stop_b_w), .en_a(en_a_w), .raw(raw_w),
      .irq(irq)
   );

   // channel A is full width so it can carry the chained count
   tmr_core #(.CW(FULL_W), .PW(PS_W), .PS_EN(PRESCALE_EN)) u_chan_a (
      .clk(clk), .rst_n(rst_n), .start_i(start_a_w), .stop_i(stop_a_w),
      .trig_i(trig_a), .mode_i(mode_a_w), .load_i(load_a_eff_w),
      .pre_i(pre_a_w), .cnt_o(cnt_a_w), .ps_o(ps_a_w), .timeout_o(tmo_a_w),
      .waiting_o(wait_a_w), .done_o(done_a_w)
   );

   tmr_core #(.CW(HALF_W), .PW(PS_W), .PS_EN(PRESCALE_EN)) u_chan_b (
      .clk(clk), .rst_n(rst_n), .start_i(start_b_w), .stop_i(stop_b_w),
      .trig_i(trig_b), .mode_i(mode_b_w), .load_i(load_b_w),
      .pre_i(pre_b_w), .cnt_o(cnt_b_w), .ps_o(ps_b_w), .timeout_o(tmo_b_w),
      .waiting_o(wait_b_w), .done_o(done_b_w)
   );

   logic unused_wait_b;
   assign unused_wait_b = wait_b_w;
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int FULL_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] addr,
   input logic [FULL_W-1:0] wdata,
   input logic              irq,
   input logic              split,
   input logic              en_a,
   input logic              tmo_a,
   input logic              tmo_b,
   input logic              per_a,
   input logic              up_a,
   input logic [FULL_W-1:0] cnt_a,
   input logic [FULL_W-1:0] load_a_eff,
   input logic [1:0]        raw,
   input logic              wait_a,
   input logic              trig_a
);
   assert_oneshot_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_a && !per_a |=> !en_a);

   assert_sticky_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
      raw[0] && !(wr_en && addr == RG_CLR && wdata[0]) |=> raw[0]);

   assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en && (addr == RG_CLR || addr == RG_MASK)));

   assert_hold_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wait_a && !trig_a && !wr_en |=> $stable(cnt_a));

   assert_down_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_a && per_a && !up_a && !wr_en |=> cnt_a == $past(load_a_eff));

   assert_chain_b_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !split && $past(!split) |-> !tmo_b);
endmodule

bind split_interval_timer tmr_checker #(.FULL_W(FULL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .irq(irq), .split(split_w), .en_a(en_a_w), .tmo_a(tmo_a_w),
   .tmo_b(tmo_b_w), .per_a(mode_a_w.periodic), .up_a(mode_a_w.up),
   .cnt_a(cnt_a_w), .load_a_eff(load_a_eff_w), .raw(raw_w),
   .wait_a(wait_a_w), .trig_a(trig_a)
);

// File: tb/split_interval_timer_tb.sv
`timescale 1ns/1ps
module split_interval_timer_tb;
   import tmr_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = 4'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        trig_a = 1'b0, trig_b = 1'b0;
   logic        irq;
   int          n_chk = 0, n_fail = 0;
   bit          mon_on = 1'b0;

   always #10 clk = ~clk;

   split_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .trig_a(trig_a), .trig_b(trig_b), .irq(irq)
   );

   // ---------------- behavioural reference ----------------
   int          m_cfg;
   logic [2:0]  m_mode [2];
   logic [31:0] m_cnt [2];
   logic [7:0]  m_ps [2];
   int          m_st [2];          // 0 idle, 1 waiting, 2 running
   bit          m_en [2];
   logic [15:0] m_ld [2];
   logic [7:0]  m_pr [2];
   logic [1:0]  m_raw, m_mask;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cfg = 0; m_raw = 0; m_mask = 0;
         for (int i = 0; i < 2; i++) begin
            m_mode[i] = 0; m_cnt[i] = (i == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            m_ps[i] = 0; m_st[i] = 0; m_en[i] = 0; m_ld[i] = 16'hFFFF; m_pr[i] = 0;
         end
      end else begin
         bit split, wc;
         logic [31:0] ld [2];
         logic [7:0]  pr [2];
         logic [31:0] wmask [2];
         bit to [2], start [2], stop [2], trg [2];
         split = (m_cfg == 4);
         wc = wr_en && addr == 4'd1;
         ld[0] = split ? {16'h0, m_ld[0]} : {m_ld[1], m_ld[0]};
         pr[0] = split ? m_pr[0] : 8'h0;
         ld[1] = {16'h0, m_ld[1]};
         pr[1] = m_pr[1];
         wmask[0] = 32'hFFFF_FFFF; wmask[1] = 32'h0000_FFFF;
         trg[0] = trig_a; trg[1] = trig_b;
         start[0] = wc && wdata[0] && !m_en[0];
         stop[0]  = wc && !wdata[0] && m_en[0];
         start[1] = split && wc && wdata[1] && !m_en[1];
         stop[1]  = (wc && !wdata[1] && m_en[1]) || !split;
         for (int i = 0; i < 2; i++) begin
            bit up, per;
            up = m_mode[i][1]; per = m_mode[i][0];
            to[i] = (m_st[i] == 2) &&
                    (up ? (m_cnt[i] == ld[i] && m_ps[i] == pr[i])
                        : (m_cnt[i] == 0 && m_ps[i] == 0));
            if (start[i]) begin
               m_cnt[i] = up ? 0 : ld[i];
               m_ps[i]  = up ? 0 : pr[i];
               m_st[i]  = m_mode[i][2] ? 1 : 2;
            end else if (stop[i]) begin
               m_st[i] = 0;
            end else if (m_st[i] == 1) begin
               if (trg[i]) m_st[i] = 2;
            end else if (m_st[i] == 2) begin
               if (to[i]) begin
                  if (per) begin
                     m_cnt[i] = up ? 0 : ld[i];
                     m_ps[i]  = up ? 0 : pr[i];
                  end else m_st[i] = 0;
               end else if (up) begin
                  if (m_ps[i] == pr[i]) begin
                     m_ps[i] = 0; m_cnt[i] = (m_cnt[i] + 1) & wmask[i];
                  end else m_ps[i] = m_ps[i] + 1;
               end else begin
                  if (m_ps[i] == 0) begin
                     m_ps[i] = pr[i]; m_cnt[i] = (m_cnt[i] - 1) & wmask[i];
                  end else m_ps[i] = m_ps[i] - 1;
               end
            end
         end
         if (to[0] && !m_mode[0][0]) m_en[0] = 0;
         else if (wc) m_en[0] = wdata[0];
         if (!split || (to[1] && !m_mode[1][0])) m_en[1] = 0;
         else if (wc) m_en[1] = wdata[1];
         m_raw = (m_raw & ~((wr_en && addr == 4'd12) ? wdata[1:0] : 2'b00))
                 | {to[1], to[0]};
         if (wr_en) begin
            case (addr)
               4'd0: m_cfg = int'(wdata[2:0]);
               4'd2: m_mode[0] = wdata[2:0];
               4'd3: m_mode[1] = wdata[2:0];
               4'd4: begin m_ld[0] = wdata[15:0]; if (!split) m_ld[1] = wdata[31:16]; end
               4'd5: m_ld[1] = wdata[15:0];
               4'd6: m_pr[0] = wdata[7:0];
               4'd7: m_pr[1] = wdata[7:0];
               4'd11: m_mask = wdata[1:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_read(logic [3:0] a);
      bit split;
      split = (m_cfg == 4);
      case (a)
         4'd0: return {29'h0, 3'(m_cfg)};
         4'd1: return {30'h0, m_en[1], m_en[0]};
         4'd2: return {29'h0, m_mode[0]};
         4'd3: return {29'h0, m_mode[1]};
         4'd4: return split ? {16'h0, m_ld[0]} : {m_ld[1], m_ld[0]};
         4'd5: return {16'h0, m_ld[1]};
         4'd6: return {24'h0, m_pr[0]};
         4'd7: return {24'h0, m_pr[1]};
         4'd8: return split ? {8'h0, m_ps[0], m_cnt[0][15:0]} : m_cnt[0];
         4'd9: return split ? {8'h0, m_ps[1], m_cnt[1][15:0]} : {16'h0, m_cnt[0][31:16]};
         4'd10: return {30'h0, m_raw};
         4'd11: return {30'h0, m_mask};
         default: return 32'h0;
      endcase
   endfunction

   // ---------------- checking ----------------
   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (mon_on) begin
         check("R9 irq vs model", {31'h0, irq}, {31'h0, |(m_raw & m_mask)});
         check("R10 read vs model", rdata, exp_read(addr));
      end
   end

   task automatic tick(int n);
      repeat (n) begin @(negedge clk); #2; end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk); #2;
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic chk(string tag, logic [3:0] a, logic [31:0] exp);
      addr = a; #1;
      check(tag, rdata, exp);
   endtask

   task automatic pulse_a();
      @(negedge clk); #2; trig_a = 1'b1;
      @(negedge clk); #2; trig_a = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state (chained mode after reset)
      chk("R1 cfg", RG_CFG, 32'h0);
      chk("R1 load A chained", RG_LOAD_A, 32'hFFFF_FFFF);
      chk("R1 value A", RG_VAL_A, 32'hFFFF_FFFF);
      chk("R1 value B upper half", RG_VAL_B, 32'h0000_FFFF);
      chk("R1 prescale A", RG_PRE_A, 32'h0);
      chk("R1 raw", RG_RAW, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      mon_on = 1'b1;

      // R3 R6 split down one-shot
      wr(RG_CFG, 32'h4);
      chk("R10 split value A after reset", RG_VAL_A, 32'h0000_FFFF);
      wr(RG_LOAD_A, 32'd5);
      wr(RG_MODE_A, 32'h0);
      wr(RG_CTRL, 32'h1);
      chk("R3 start loads interval", RG_VAL_A, 32'd5);
      tick(7);
      chk("R6 holds count", RG_VAL_A, 32'd0);
      chk("R6 enable self-cleared", RG_CTRL, 32'h0);
      chk("R9 raw A set", RG_RAW, 32'h1);
      check("R9 masked off", {31'h0, irq}, 32'h0);
      wr(RG_MASK, 32'h1);
      check("R9 irq on mask", {31'h0, irq}, 32'h1);
      wr(RG_CLR, 32'h1);
      check("R9 irq after clear", {31'h0, irq}, 32'h0);
      chk("R9 raw cleared", RG_RAW, 32'h0);

      // R4 R5 R8 split up periodic with prescale on B
      wr(RG_LOAD_B, 32'd3);
      wr(RG_PRE_B, 32'd2);
      wr(RG_MODE_B, 32'h3);
      wr(RG_CTRL, 32'h2);
      chk("R4 up starts at zero", RG_VAL_B, 32'h0);
      tick(11);
      chk("R4 R8 R10 terminal with stage", RG_VAL_B, 32'h0002_0003);
      tick(1);
      chk("R5 up wraps to zero", RG_VAL_B, 32'h0);

      // R3 R5 split down periodic with prescale on A
      wr(RG_LOAD_A, 32'd2);
      wr(RG_PRE_A, 32'd1);
      wr(RG_MODE_A, 32'h1);
      wr(RG_CTRL, 32'h3);
      chk("R3 start with stage", RG_VAL_A, 32'h0001_0002);
      tick(5);
      chk("R3 reaches zero", RG_VAL_A, 32'h0);
      tick(1);
      chk("R5 down reload", RG_VAL_A, 32'h0001_0002);
      wr(RG_CTRL, 32'h0);
      wr(RG_CLR, 32'h3);

      // R7 wait for trigger
      wr(RG_PRE_A, 32'd0);
      wr(RG_LOAD_A, 32'd4);
      wr(RG_MODE_A, 32'h4);
      wr(RG_CTRL, 32'h1);
      chk("R7 loaded while waiting", RG_VAL_A, 32'd4);
      tick(5);
      chk("R7 held before trigger", RG_VAL_A, 32'd4);
      pulse_a();
      chk("R7 released", RG_VAL_A, 32'd4);
      tick(1);
      chk("R7 counting", RG_VAL_A, 32'd3);
      tick(10);
      chk("R7 finished", RG_VAL_A, 32'd0);
      pulse_a();
      tick(1);
      chk("R7 idle trigger ignored", RG_VAL_A, 32'd0);
      wr(RG_CLR, 32'h3);

      // R2 R8 chained mode
      wr(RG_CFG, 32'h0);
      wr(RG_LOAD_A, 32'h0001_0001);
      wr(RG_PRE_A, 32'd5);
      wr(RG_MODE_A, 32'h1);
      wr(RG_MODE_B, 32'h2);
      wr(RG_CTRL, 32'h3);
      chk("R2 chained start", RG_VAL_A, 32'h0001_0001);
      chk("R2 chained load", RG_LOAD_A, 32'h0001_0001);
      chk("R2 B enable ignored", RG_CTRL, 32'h1);
      tick(2);
      chk("R8 borrow across halves", RG_VAL_A, 32'h0000_FFFF);
      chk("R10 B shows upper half", RG_VAL_B, 32'h0);
      wr(RG_CTRL, 32'h0);
      wr(RG_MODE_A, 32'h2);
      wr(RG_LOAD_A, 32'd3);
      wr(RG_CTRL, 32'h1);
      chk("R4 chained up start", RG_VAL_A, 32'd0);
      tick(4);
      chk("R6 chained hold", RG_VAL_A, 32'd3);
      chk("R2 only A status", RG_RAW, 32'h1);
      wr(RG_CLR, 32'h3);

      // random phase compared to model every clock
      for (int i = 0; i < 600; i++) begin
         int op;
         op = $urandom_range(0, 9);
         case (op)
            0: wr(RG_CTRL, 32'($urandom_range(0, 3)));
            1: wr(RG_MODE_A, 32'($urandom_range(0, 7)));
            2: wr(RG_MODE_B, 32'($urandom_range(0, 7)));
            3: wr(RG_LOAD_A, 32'($urandom_range(0, 6)));
            4: wr(RG_LOAD_B, 32'($urandom_range(0, 6)));
            5: wr(RG_PRE_A, 32'($urandom_range(0, 3)));
            6: wr(RG_PRE_B, 32'($urandom_range(0, 3)));
            7: wr(RG_CLR, 32'($urandom_range(0, 3)));
            8: wr(RG_MASK, 32'($urandom_range(0, 3)));
            default: begin
               if ($urandom_range(0, 5) == 0)
                  wr(RG_CFG, ($urandom_range(0, 2) != 0) ? 32'h4 : 32'h0);
               else begin
                  @(negedge clk); #2;
                  trig_a = 1'($urandom_range(0, 1));
                  trig_b = 1'($urandom_range(0, 1));
                  @(negedge clk); #2;
                  trig_a = 1'b0; trig_b = 1'b0;
               end
            end
         endcase
         addr = 4'($urandom_range(0, 12));
         tick($urandom_range(0, 6));
      end

      mon_on = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule